// File: doc/BRIEF.md
# Nine-Bit Serial Command/Data Receiver

This block is the slave-side receive path of a three-wire clocked serial link that a host uses to feed a display controller. Every frame is nine bits long. The first bit is a flag that marks the frame as a command (0) or a data byte (1). The next eight bits are the byte itself, most significant bit first. Bits are taken on the rising edge of the serial clock while the active-low select is held low. Frames may follow one another with no gap for as long as select stays low.

The serial-clock side assembles the frame and flips a toggle bit. A two-flop synchronizer carries that toggle into the system clock domain, where it is turned into a one-cycle valid strobe that comes with the byte and its flag. Each data frame advances a display-memory address counter. A parameter chooses whether the counter wraps to zero or holds at its last value when it reaches the top of the range. Driving select high clears the serial side. So does the asynchronous reset, which also clears the system side.

Top module: `s3w_rx`

## Requirements
- R1: While rst_n is low and right after it rises, rx_valid is 0, rx_byte is 0, rx_is_data is 0 and ram_addr is 0.
- R2: The eight bits taken on serial clock rises 2 through 9 of a frame appear on rx_byte, the first of them as bit 7 and the last as bit 0. rx_byte keeps its value in cycles where rx_valid is 0.
- R3: The bit taken on the first serial clock rise of a frame appears on rx_is_data with that frame: 0 means command and 1 means data.
- R4: rx_valid is high for exactly one system cycle per complete frame. It is visible after the third rising edge of clk that follows the ninth serial clock rise.
- R5: While cs_n stays low, the serial clock rise after a frame's ninth bit takes the flag of the next frame, with no gap needed.
- R6: When cs_n goes high partway through a frame, the partial frame produces no strobe. The first bit after cs_n goes low again is a flag bit.
- R7: Serial clock pulses that arrive while cs_n is high produce no strobe and do not shift any bits.
- R8: One cycle after a strobe with rx_is_data=1, ram_addr is one more than before. A strobe with rx_is_data=0 leaves ram_addr unchanged.
- R9: A data strobe that arrives while ram_addr equals ADDR_LAST sets ram_addr to 0 when WRAP_EN=1. When WRAP_EN=0, ram_addr stays at ADDR_LAST.
- R10: A low pulse on rst_n partway through a frame drops that frame. If cs_n is low when rst_n rises, the next bit taken is a flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cs_n | input | 1 | Active-low select; high clears the serial side |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| sdin | input | 1 | Serial data input |
| rx_byte | output | BYTE_W | Last received byte |
| rx_is_data | output | 1 | Flag of the last frame: 1 data, 0 command |
| rx_valid | output | 1 | One-cycle strobe per received frame |
| ram_addr | output | ADDR_W | Display-memory address counter |

## Verification
The bench drives each serial clock edge on a falling clk edge. This makes the crossing deterministic: a strobe is due exactly three clk rises after the ninth serial rise, and the address changes one rise after that. The bench model stamps each finished frame with its due cycle. After every clk rise it compares rx_valid, rx_byte, rx_is_data and ram_addr against what the model expects for that exact cycle. A second instance built with WRAP_EN=0 and a small range is checked against its own saturating model.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic              is_data;
        logic [BYTE_W-1:0] payload;
    } frame_t;
endpackage

// File: rtl/s3w_shift.sv
module s3w_shift
    import s3w_pkg::*;
(
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   sclk,
    input  logic   sdin,
    output frame_t frame_o,
    output logic   tgl_o
);
    localparam int FRAME_W = BYTE_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
    } bit_st_t;

    typedef struct packed {
        frame_t frame;
        logic   tgl;
    } hold_st_t;

    bit_st_t  bit_d, bit_q;
    hold_st_t hold_d, hold_q;
    logic     ser_rst;

    assign ser_rst = !rst_n || cs_n;

    always_comb begin
        bit_d  = bit_q;
        hold_d = hold_q;
        bit_d.sh = {bit_q.sh[BYTE_W-2:0], sdin};
        if (bit_q.cnt == LAST_BIT) begin
            bit_d.cnt            = '0;
            hold_d.frame.is_data = bit_q.sh[BYTE_W-1];
            hold_d.frame.payload = {bit_q.sh[BYTE_W-2:0], sdin};
            hold_d.tgl           = ~hold_q.tgl;
        end else begin
            bit_d.cnt = bit_q.cnt + 1'b1;
        end
    end

    // frame assembly: cleared by select high or reset
    always_ff @(posedge sclk or posedge ser_rst) begin
        if (ser_rst) bit_q <= '0;
        else         bit_q <= bit_d;
    end

    // completed-frame hold and toggle: cleared only by reset
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign frame_o = hold_q.frame;
    assign tgl_o   = hold_q.tgl;

    // R5
    cnt_bound_chk: assert property (@(posedge sclk) disable iff (ser_rst)
        bit_q.cnt <= LAST_BIT);
endmodule

// File: rtl/s3w_cdc.sv
module s3w_cdc
    import s3w_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tgl_i,
    input  frame_t frame_i,
    output logic   valid_o,
    output frame_t frame_o
);
    typedef struct packed {
        logic [SYNC_N:0] sync;
        logic            valid;
        frame_t          frame;
    } cdc_st_t;

    cdc_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[SYNC_N-1:0], tgl_i};
        st_d.valid = st_q.sync[SYNC_N-1] ^ st_q.sync[SYNC_N];
        if (st_d.valid) st_d.frame = frame_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign frame_o = st_q.frame;

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(frame_o)));
endmodule

// File: rtl/s3w_addr.sv
module s3w_addr #(
    parameter int ADDR_W    = 8,
    parameter int ADDR_LAST = 131,
    parameter bit WRAP_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              is_data_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(ADDR_LAST);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (valid_i && is_data_i) begin
            if (addr_q != TOP)  addr_d = addr_q + 1'b1;
            else if (WRAP_EN)   addr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R8
    cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !is_data_i) |=> $stable(addr_o));
    // R8
    data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_data_i && addr_o != TOP) |=> addr_o == $past(addr_o) + 1'b1);
    // R9
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_data_i && addr_o == TOP) |=> addr_o == (WRAP_EN ? '0 : TOP));
endmodule

// File: rtl/s3w_rx.sv
module s3w_rx
    import s3w_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ADDR_LAST = 131,
    parameter bit WRAP_EN   = 1'b1,
    parameter int SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              rx_valid,
    output logic [ADDR_W-1:0] ram_addr
);
    frame_t ser_frame, sys_frame;
    logic   ser_tgl;

    s3w_shift u_shift (
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdin    (sdin),
        .frame_o (ser_frame),
        .tgl_o   (ser_tgl)
    );

    s3w_cdc #(.SYNC_N(SYNC_N)) u_cdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl_i   (ser_tgl),
        .frame_i (ser_frame),
        .valid_o (rx_valid),
        .frame_o (sys_frame)
    );

    s3w_addr #(
        .ADDR_W    (ADDR_W),
        .ADDR_LAST (ADDR_LAST),
        .WRAP_EN   (WRAP_EN)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (rx_valid),
        .is_data_i (sys_frame.is_data),
        .addr_o    (ram_addr)
    );

    assign rx_byte    = sys_frame.payload;
    assign rx_is_data = sys_frame.is_data;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!rx_valid && ram_addr == '0));
endmodule

// File: tb/s3w_rx_tb.sv
module s3w_rx_tb;
    localparam int LAST_A = 131;
    localparam int SAT_LAST = 3;

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdin = 0;
    logic [7:0] rx_byte, sat_byte;
    logic rx_is_data, rx_valid, sat_is_data, sat_valid;
    logic [7:0] ram_addr, sat_addr;

    always #4 clk = ~clk;

    s3w_rx u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .rx_byte(rx_byte), .rx_is_data(rx_is_data), .rx_valid(rx_valid), .ram_addr(ram_addr));

    s3w_rx #(.ADDR_LAST(SAT_LAST), .WRAP_EN(1'b0)) u_sat (.clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .sclk(sclk), .sdin(sdin), .rx_byte(sat_byte), .rx_is_data(sat_is_data),
        .rx_valid(sat_valid), .ram_addr(sat_addr));

    typedef struct { int due; bit d; logic [7:0] b; } ev_t;
    ev_t evq[$];
    int cyc = 0, n_run = 0, n_fail = 0, n_seen = 0, nb = 0;
    logic [8:0] acc = '0;
    int exp_addr = 0, exp_sat = 0;
    bit inc_next = 0, done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // per-cycle comparison against the behavioural model
    initial forever begin
        @(posedge clk);
        cyc++;
        #2;
        if (!rst_n) begin
            chk(rx_valid == 0, "R1", rx_valid, 0);
            chk(ram_addr == 0, "R1", ram_addr, 0);
        end else begin
            if (inc_next) begin
                exp_addr = (exp_addr == LAST_A) ? 0 : exp_addr + 1;
                exp_sat  = (exp_sat == SAT_LAST) ? SAT_LAST : exp_sat + 1;
                inc_next = 0;
            end
            chk(ram_addr == exp_addr, "R8", ram_addr, exp_addr);
            chk(sat_addr == exp_sat, "R9", sat_addr, exp_sat);
            if (evq.size() > 0 && evq[0].due == cyc) begin
                chk(rx_valid == 1, "R4", rx_valid, 1);
                chk(rx_byte == evq[0].b, "R2", rx_byte, evq[0].b);
                chk(rx_is_data == evq[0].d, "R3", rx_is_data, evq[0].d);
                if (evq[0].d) inc_next = 1;
                void'(evq.pop_front());
            end else begin
                chk(rx_valid == 0, "R4", rx_valid, 0);
            end
            if (rx_valid) n_seen++;
        end
    end

    task automatic sbit(input bit b);
        @(negedge clk); sdin = b;
        repeat (3) @(negedge clk);
        sclk = 1;
        if (!cs_n && rst_n) begin
            acc = {acc[7:0], b};
            nb++;
            if (nb == 9) begin
                evq.push_back('{due: cyc + 3, d: acc[8], b: acc[7:0]});
                nb = 0;
            end
        end
        repeat (4) @(negedge clk);
        sclk = 0;
    endtask

    task automatic frame(input bit d, input logic [7:0] b);
        sbit(d);
        for (int i = 7; i >= 0; i--) sbit(b[i]);
    endtask

    task automatic sel(input bit v);
        @(negedge clk); cs_n = v;
        if (v) nb = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(rx_byte == 0, "R1", rx_byte, 0);
        chk(rx_is_data == 0, "R1", rx_is_data, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(ram_addr == 0 && rx_valid == 0, "R1", ram_addr, 0);

        // R2 R3: command then data, different patterns
        sel(0);
        frame(0, 8'hA5);
        settle();
        frame(1, 8'h3C);
        settle();
        // R5 back-to-back frames
        base = n_seen;
        frame(1, 8'h01); frame(1, 8'h80); frame(0, 8'hFF); frame(1, 8'h00);
        settle();
        chk(n_seen == base + 4, "R5", n_seen - base, 4);

        // R6 abort mid-frame by select high
        base = n_seen;
        sbit(1); sbit(0); sbit(1); sbit(1);
        sel(1);
        // R7 clocks while deselected
        sbit(1); sbit(1); sbit(0);
        settle();
        chk(n_seen == base, "R7", n_seen - base, 0);
        sel(0);
        frame(0, 8'h5A);
        settle();
        chk(n_seen == base + 1, "R6", n_seen - base, 1);

        // R10 reset mid-frame with select low
        base = n_seen;
        sbit(1); sbit(1); sbit(0);
        @(negedge clk); rst_n = 0; nb = 0; exp_addr = 0; exp_sat = 0; inc_next = 0;
        repeat (3) @(negedge clk);
        chk(ram_addr == 0, "R10", ram_addr, 0);
        rst_n = 1;
        @(negedge clk);
        frame(1, 8'hC3);
        settle();
        chk(n_seen == base + 1, "R10", n_seen - base, 1);

        // R9 walk the address to the top and past it
        while (exp_addr != LAST_A) frame(1, 8'(exp_addr));
        settle();
        chk(ram_addr == LAST_A, "R9", ram_addr, LAST_A);
        frame(1, 8'h77);
        settle();
        chk(ram_addr == 0, "R9", ram_addr, 0);
        chk(sat_addr == SAT_LAST, "R9", sat_addr, SAT_LAST);
        frame(0, 8'h11);
        settle();
        chk(ram_addr == 0, "R8", ram_addr, 0);
        sel(1);
        settle();
        chk(evq.size() == 0, "R4", evq.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule